// File: doc/BRIEF.md
# SPI Serial Clock Rate Generator

This block turns a fast functional clock into the serial clock of an SPI host engine. The clock is divided in two cascaded stages. A linear prescaler divides by (n+1), with n an 8-bit value from 0 to 255. A power-of-two stage then divides by 2^N, with N from 0 to 3. Each half-period of the serial clock therefore lasts (n+1)·2^N functional cycles, and the serial bit rate is f_clk / (2·(n+1)·2^N). The slowest setting, n=255 with N=3, divides by 4096 per full serial period.

The engine raises `run_i` for the whole frame. The divider values and the clock polarity are captured on the cycle the frame starts, so writes during a frame take effect only from the next frame. While `run_i` is low, the serial clock rests at the polarity level. An auto-stop request on `hold_i` freezes the count and the clock level in the middle of a frame. Rise and fall strobes tell the shift logic when to sample and when to launch data. The setting n=0 with N=0 would give half the functional clock, which is prohibited. The block flags that setting and runs at the next legal rate, n=1 with N=0.

Top module: `spi_rate_gen`

## Requirements
- R1: During and right after reset, `sck_o`, `rise_o`, `fall_o` and `bad_cfg_o` are all 0.
- R2: While `run_i` is low, `sck_o` takes the value of `cpol_i` one cycle later, and no strobe is produced.
- R3: The clock edge at which `run_i` is first seen high is the frame start. `sck_o` first toggles H edges after the frame start, then every H unheld edges after that, with H = (n+1)·2^N taken from `div_lin_i` and `div_exp_i`.
- R4: `rise_o` is a one-cycle pulse in the cycle where `sck_o` has just gone from 0 to 1, and `fall_o` is the same for 1 to 0. The two are never high together, and no strobe is followed directly by another one.
- R5: If `div_lin_i`=0 and `div_exp_i`=0 at the frame start, `bad_cfg_o` is 1 from the following cycle until the frame ends, and H is 2.
- R6: For any other setting, `bad_cfg_o` stays 0 during the frame.
- R7: Changes to `div_lin_i`, `div_exp_i` or `cpol_i` after the frame start have no effect on the frame timing.
- R8: A clock edge with `hold_i` high during a frame is not counted. `sck_o` keeps its level, no strobe occurs, and counting resumes from where it stopped once the hold is released.
- R9: Dropping `run_i` ends the frame. `sck_o` returns to `cpol_i` one cycle later, and the next frame starts counting from zero.
- R10: With n=255 and N=3, each half-period lasts 2048 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Functional clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_lin_i | input | 8 | Linear divider value n |
| div_exp_i | input | 2 | Power-of-two exponent N |
| cpol_i | input | 1 | Idle level of the serial clock |
| run_i | input | 1 | Frame active request |
| hold_i | input | 1 | Auto-stop hold, freezes the count |
| sck_o | output | 1 | Serial clock level |
| rise_o | output | 1 | Serial clock rising strobe |
| fall_o | output | 1 | Serial clock falling strobe |
| bad_cfg_o | output | 1 | Prohibited divider setting captured |

## Verification
The hardest case to reach is a hold that lands partway through a half-period. In that case the inner prescaler and the outer power-of-two counter are both mid-count and must resume exactly. The driver raises `hold_i` for a stretch that does not start on a half-period boundary and is longer than one half-period. It models only the number of unheld edges, so any slip in the counters shows up as a strobe in the wrong cycle. A frame in which the divider and polarity inputs are rewritten a few cycles after the start checks that the captured setting is the one used.

// File: rtl/spi_rate_gen_pkg.sv
package spi_rate_gen_pkg;
  localparam int unsigned LIN_W = 8;
  localparam int unsigned EXP_W = 2;

  typedef struct packed {
    logic [LIN_W-1:0] lin;
    logic [EXP_W-1:0] exp;
  } rate_cfg_t;
endpackage

// File: rtl/srg_ctrl.sv
module srg_ctrl
  import spi_rate_gen_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [LIN_W-1:0] div_lin_i,
  input  logic [EXP_W-1:0] div_exp_i,
  output logic             run_q_o,
  output logic             start_o,
  output rate_cfg_t        cfg_o,
  output logic             bad_o
);
  logic illegal;
  assign illegal = (div_lin_i == '0) && (div_exp_i == '0);
  assign start_o = run_i & ~run_q_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q_o <= 1'b0;
      cfg_o   <= '0;
      bad_o   <= 1'b0;
    end else begin
      run_q_o <= run_i;
      if (!run_i) begin
        bad_o <= 1'b0;
      end else if (start_o) begin
        bad_o     <= illegal;
        // prohibited fastest rate falls back to n=1, N=0
        cfg_o.lin <= illegal ? LIN_W'(1) : div_lin_i;
        cfg_o.exp <= div_exp_i;
      end
    end
  end
endmodule

// File: rtl/srg_prescale.sv
module srg_prescale #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic [W-1:0] lim_i,
  output logic         tick_o
);
  logic [W-1:0] cnt_q;
  assign tick_o = en_i && (cnt_q == lim_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else if (en_i)    cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/srg_expstage.sv
module srg_expstage #(
  parameter int unsigned EW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          tick_i,
  input  logic [EW-1:0] exp_i,
  output logic          half_o
);
  localparam int unsigned CW = (1 << EW) - 1;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] term;

  always_comb begin
    term = '0;
    for (int i = 0; i < CW; i++) begin
      if (i < int'(exp_i)) term[i] = 1'b1;
    end
  end

  assign half_o = tick_i && (cnt_q == term);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (half_o)  cnt_q <= '0;
    else if (tick_i)  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/srg_sck.sv
module srg_sck (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic half_i,
  input  logic cpol_i,
  output logic sck_o,
  output logic rise_o,
  output logic fall_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_o  <= 1'b0;
      rise_o <= 1'b0;
      fall_o <= 1'b0;
    end else begin
      rise_o <= active_i & half_i & ~sck_o;
      fall_o <= active_i & half_i &  sck_o;
      if (!active_i)   sck_o <= cpol_i;
      else if (half_i) sck_o <= ~sck_o;
    end
  end
endmodule

// File: rtl/spi_rate_gen.sv
module spi_rate_gen
  import spi_rate_gen_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LIN_W-1:0] div_lin_i,
  input  logic [EXP_W-1:0] div_exp_i,
  input  logic             cpol_i,
  input  logic             run_i,
  input  logic             hold_i,
  output logic             sck_o,
  output logic             rise_o,
  output logic             fall_o,
  output logic             bad_cfg_o
);
  logic      run_q, start, tick, half, active, cnt_en, cnt_clr;
  rate_cfg_t cfg;

  // active: frame running at this edge (not the start edge, not the stop edge)
  assign active  = run_q & run_i;
  assign cnt_en  = active & ~hold_i;
  assign cnt_clr = ~active;

  srg_ctrl u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run_i),
    .div_lin_i (div_lin_i),
    .div_exp_i (div_exp_i),
    .run_q_o   (run_q),
    .start_o   (start),
    .cfg_o     (cfg),
    .bad_o     (bad_cfg_o)
  );

  srg_prescale #(.W(LIN_W)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (cnt_clr),
    .en_i   (cnt_en),
    .lim_i  (cfg.lin),
    .tick_o (tick)
  );

  srg_expstage #(.EW(EXP_W)) u_exp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (cnt_clr),
    .tick_i (tick),
    .exp_i  (cfg.exp),
    .half_o (half)
  );

  srg_sck u_sck (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (active),
    .half_i   (half),
    .cpol_i   (cpol_i),
    .sck_o    (sck_o),
    .rise_o   (rise_o),
    .fall_o   (fall_o)
  );
endmodule

// File: rtl/spi_rate_gen_chk.sv
module spi_rate_gen_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cpol_i,
  input logic run_i,
  input logic hold_i,
  input logic run_q,
  input logic sck_o,
  input logic rise_o,
  input logic fall_o
);
  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rise_o && fall_o)); // R4
  AST_RISE_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |-> sck_o); // R4
  AST_FALL_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |-> !sck_o); // R4
  AST_STROBE_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_o || fall_o) |=> !(rise_o || fall_o)); // R4
  AST_IDLE_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (sck_o == $past(cpol_i))); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q |-> !(rise_o || fall_o)); // R2
  AST_HOLD_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && run_i && hold_i) |=> ($stable(sck_o) && !rise_o && !fall_o)); // R8
endmodule

bind spi_rate_gen spi_rate_gen_chk u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .cpol_i (cpol_i),
  .run_i  (run_i),
  .hold_i (hold_i),
  .run_q  (run_q),
  .sck_o  (sck_o),
  .rise_o (rise_o),
  .fall_o (fall_o)
);

// File: tb/spi_rate_gen_test.sv
`timescale 1ns/1ps
module spi_rate_gen_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] div_lin = '0;
  logic [1:0] div_exp = '0;
  logic       cpol = 1'b0, run = 1'b0, hold = 1'b0;
  logic       sck, rise, fall, bad;

  int checks = 0, errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  typedef struct { int edge_n; bit lvl; } exp_t;
  exp_t sb[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  spi_rate_gen uut (
    .clk_i(clk), .rst_ni(rst_n), .div_lin_i(div_lin), .div_exp_i(div_exp),
    .cpol_i(cpol), .run_i(run), .hold_i(hold),
    .sck_o(sck), .rise_o(rise), .fall_o(fall), .bad_cfg_o(bad)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, expv);
    end
  endtask

  // monitor: pop expected edges as strobes appear
  always @(posedge clk) begin
    #1;
    if (rst_n && (rise || fall)) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R4 unexpected strobe at edge", cyc, -1);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(cyc == e.edge_n, "R3/R8 edge timing", cyc, e.edge_n);
        chk(rise == e.lvl && fall == !e.lvl, "R4 strobe kind", {rise, fall}, e.lvl ? 2 : 1);
        chk(sck == e.lvl, "R4 sck level", sck, e.lvl);
      end
    end
  end

  task automatic frame(input int n, input int ex, input bit pol, input int tog,
                       input int hs, input int hl, input bit chg);
    int h, cnt, k, idx;
    bit lvl;
    bit illegal;
    illegal = (n == 0 && ex == 0);
    h = (illegal ? 2 : n + 1) << ex;
    cnt = 0; k = 0; idx = 0; lvl = pol;
    @(negedge clk);
    div_lin = 8'(n); div_exp = 2'(ex); cpol = pol; run = 1'b1; hold = 1'b0;
    while (k < tog) begin
      @(negedge clk);
      idx++;
      if (idx == 1) chk(bad == illegal, illegal ? "R5 bad flag" : "R6 bad flag", bad, illegal);
      hold = (idx >= hs) && (idx < hs + hl);
      if (chg && idx == 3) begin
        div_lin = 8'd7; div_exp = 2'd0; cpol = ~pol; // R7 ignored mid-frame
      end
      if (!hold) begin
        cnt++;
        if (cnt == h) begin
          cnt = 0; k++; lvl = ~lvl;
          sb.push_back('{cyc + 1, lvl});
        end
      end
    end
    @(negedge clk);
    chk(bad == illegal, "R5/R6 bad flag held", bad, illegal);
    run = 1'b0; hold = 1'b0; cpol = pol;
    @(negedge clk);
    chk(sck == pol, "R9 sck back to idle level", sck, pol);
    chk(bad == 1'b0, "R9 bad flag cleared", bad, 0);
    repeat (3) @(negedge clk);
    chk(sb.size() == 0, "R3 all expected edges seen", sb.size(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(sck == 0 && rise == 0 && fall == 0 && bad == 0, "R1 reset outputs", {sck, rise, fall, bad}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sck == 0 && bad == 0, "R1 after reset", {sck, bad}, 0);
    cpol = 1'b1;
    @(negedge clk);
    chk(sck == 1'b1, "R2 idle follows polarity high", sck, 1);
    cpol = 1'b0;
    @(negedge clk);
    chk(sck == 1'b0, "R2 idle follows polarity low", sck, 0);
    frame(2, 1, 1'b0, 6, 1000, 0, 1'b0);      // R3 R6, H=6
    frame(0, 0, 1'b0, 5, 1000, 0, 1'b0);      // R5, H=2
    frame(4, 2, 1'b1, 4, 1000, 0, 1'b1);      // R7, H=20
    frame(1, 3, 1'b0, 4, 10, 25, 1'b0);       // R8, H=16, hold mid half-period
    frame(0, 1, 1'b1, 3, 3, 1, 1'b0);         // R9 back-to-back restart, H=2
    frame(255, 3, 1'b0, 2, 1000, 0, 1'b0);    // R10, H=2048
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      chk(1'b0, "watchdog expired", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule